// File: doc/BRIEF.md
# Issue Latency Scoreboard

This block sits at the issue point of an in-order pipeline. It decides, one operation at a time, whether the operation may leave issue this cycle. Every operation carries an operation class. It may name a destination register and up to two source registers. The block keeps, for each architectural register, the class of its most recent producer and the number of cycles since that producer issued. A source is ready once that age reaches the producer-to-consumer latency.

The latency is normally fixed by the producer class alone. A few producer/consumer class pairs use a different value, either longer or shorter than the default. Multiplies, divides, FP divide and square root also keep their execution unit occupied for many cycles. While that unit is occupied, a later operation aimed at the same unit is held even if its operands are ready.

The block raises `stall` for the operation presented this cycle. When `stall` is low and `issueValid` is high, the operation is accepted. In that cycle the destination record and the unit occupancy are updated.

Top module: `lat_scoreboard`

## Requirements
- R1: After reset every register reads as ready and no unit is occupied, so any operation presented in the first cycle is accepted.
- R2: Class codes on `opClass` and their default latencies: 0 simple integer 2, 1 integer load 4, 2 FP load 6, 3 FP arithmetic 6, 4 FP compare 5, 5 compare-to-register 3, 6 record-form compare 2, 13 simple vector 2, 14 complex vector 5, 15 vector float 8, 16 vector permute 2, 17 vector load 6, 18 branch 2, 19 condition-register logic 2, 20 vector store 2, and codes 21 to 31 behave as code 0. A consumer that reads a register written by an operation accepted in cycle t is accepted no earlier than cycle t plus the latency.
- R3: `stall` is high exactly when `issueValid` is high and a valid source is not yet ready or the operation's unit is occupied. With `issueValid` low, `stall` is low.
- R4: A record-form compare (6) read by a branch (18) or condition-register logic (19) uses latency 4. Read by any other class, it uses 2.
- R5: Read by a vector permute (16), the latency is 3 after a simple vector (13), 6 after a complex vector (14), 9 after a vector float (15) and 4 after a vector load (17).
- R6: Read by a vector store (20), the latency is 4 after a simple vector or permute, 7 after a complex vector and 10 after a vector float.
- R7: Short multiply (7, latency 5) occupies the first integer unit for 4 cycles. Long multiply (8, latency 7) occupies it for 6 cycles. Classes 0, 5, 6, 7 and 8 use that unit.
- R8: Word divide (9, latency 36) occupies the second integer unit for 35 cycles. Doubleword divide (10, latency 68) occupies it for 67 cycles. Only the divides use that unit, so simple integer work is not held by a divide.
- R9: FP divide (11, latency 33) occupies the FP unit for 28 cycles. Square root (12, latency 40) occupies it for 35 cycles. Classes 3, 4, 11 and 12 use the FP unit.
- R10: A stalled operation changes nothing: its destination keeps its previous readiness, and its unit is not re-occupied.
- R11: With `dstValid` low no register is written, and a source whose valid bit is low never causes a stall.
- R12: A newer accepted write to a register replaces the older one, so readiness follows the latest producer only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An operation is presented this cycle |
| opClass | input | 5 | Operation class code (see R2) |
| dstValid | input | 1 | Operation writes `dstTag` |
| dstTag | input | TAG_W | Destination register |
| src0Valid | input | 1 | First source is used |
| src0Tag | input | TAG_W | First source register |
| src1Valid | input | 1 | Second source is used |
| src1Tag | input | TAG_W | Second source register |
| stall | output | 1 | Hold the presented operation this cycle |

## Verification
The hardest situations to reach are the long-occupancy windows. A divide blocks its unit for up to 67 cycles, and the bench must hit that window while keeping the first integer unit free. It must also present a second operation that stalls only because of the unit, with no operand hazard. Directed sequences let the machine drain, issue one long producer and then retry a single consumer until it is accepted. The counted stall cycles are compared with latency minus one or occupancy minus one. A random phase over eight registers and all classes then mixes overrides, unit conflicts and overwrites. A behavioural model checks it every cycle.

// File: rtl/lat_sb_pkg.sv
package lat_sb_pkg;
  localparam int LAT_W = 7;
  localparam int NUM_UNITS = 3;

  typedef enum logic [4:0] {
    CL_INT = 5'd0, CL_LOAD = 5'd1, CL_FPLOAD = 5'd2, CL_FPOP = 5'd3,
    CL_FPCMP = 5'd4, CL_CMPREG = 5'd5, CL_RECCMP = 5'd6, CL_MULS = 5'd7,
    CL_MULL = 5'd8, CL_DIVW = 5'd9, CL_DIVD = 5'd10, CL_FDIV = 5'd11,
    CL_FSQRT = 5'd12, CL_VSIMP = 5'd13, CL_VCPLX = 5'd14, CL_VFLT = 5'd15,
    CL_VPERM = 5'd16, CL_VLOAD = 5'd17, CL_BRANCH = 5'd18, CL_CRLOG = 5'd19,
    CL_VSTORE = 5'd20
  } opClass_t;

  typedef enum logic [1:0] {
    UNIT_NONE = 2'd0, UNIT_IU1 = 2'd1, UNIT_IU2 = 2'd2, UNIT_FPU = 2'd3
  } unit_t;

  typedef struct packed {
    logic             regWr;
    logic             unitLoad;
    unit_t            unitSel;
    logic [LAT_W-1:0] occLoad;
  } sbStrobe_t;

  function automatic logic [LAT_W-1:0] baseLat(input opClass_t c);
    case (c)
      CL_LOAD:   return LAT_W'(4);
      CL_FPLOAD: return LAT_W'(6);
      CL_FPOP:   return LAT_W'(6);
      CL_FPCMP:  return LAT_W'(5);
      CL_CMPREG: return LAT_W'(3);
      CL_MULS:   return LAT_W'(5);
      CL_MULL:   return LAT_W'(7);
      CL_DIVW:   return LAT_W'(36);
      CL_DIVD:   return LAT_W'(68);
      CL_FDIV:   return LAT_W'(33);
      CL_FSQRT:  return LAT_W'(40);
      CL_VCPLX:  return LAT_W'(5);
      CL_VFLT:   return LAT_W'(8);
      CL_VLOAD:  return LAT_W'(6);
      default:   return LAT_W'(2);
    endcase
  endfunction

  // Pairwise producer/consumer latency, falling back to the producer default.
  function automatic logic [LAT_W-1:0] effLat(input opClass_t p, input opClass_t c);
    logic [LAT_W-1:0] lat;
    lat = baseLat(p);
    if (p == CL_RECCMP && (c == CL_BRANCH || c == CL_CRLOG)) lat = LAT_W'(4);
    if (c == CL_VPERM) begin
      case (p)
        CL_VSIMP: lat = LAT_W'(3);
        CL_VCPLX: lat = LAT_W'(6);
        CL_VFLT:  lat = LAT_W'(9);
        CL_VLOAD: lat = LAT_W'(4);
        default:  ;
      endcase
    end
    if (c == CL_VSTORE) begin
      case (p)
        CL_VSIMP, CL_VPERM: lat = LAT_W'(4);
        CL_VCPLX:           lat = LAT_W'(7);
        CL_VFLT:            lat = LAT_W'(10);
        default:            ;
      endcase
    end
    return lat;
  endfunction

  function automatic unit_t unitOf(input opClass_t c);
    case (c)
      CL_INT, CL_CMPREG, CL_RECCMP, CL_MULS, CL_MULL: return UNIT_IU1;
      CL_DIVW, CL_DIVD:                                return UNIT_IU2;
      CL_FPOP, CL_FPCMP, CL_FDIV, CL_FSQRT:            return UNIT_FPU;
      default:                                         return UNIT_NONE;
    endcase
  endfunction

  function automatic logic [LAT_W-1:0] occOf(input opClass_t c);
    case (c)
      CL_MULS:  return LAT_W'(4);
      CL_MULL:  return LAT_W'(6);
      CL_DIVW:  return LAT_W'(35);
      CL_DIVD:  return LAT_W'(67);
      CL_FDIV:  return LAT_W'(28);
      CL_FSQRT: return LAT_W'(35);
      default:  return LAT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/lat_scoreboard_dp.sv
module lat_scoreboard_dp
  import lat_sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int TAG_W    = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  sbStrobe_t            strobe,
  input  logic [TAG_W-1:0]     dstTag,
  input  opClass_t             opClass,
  input  logic [TAG_W-1:0]     src0Tag,
  input  logic [TAG_W-1:0]     src1Tag,
  output logic [LAT_W-1:0]     src0Age,
  output opClass_t             src0Cls,
  output logic [LAT_W-1:0]     src1Age,
  output opClass_t             src1Cls,
  output logic [NUM_UNITS-1:0] unitBusy
);
  localparam logic [LAT_W-1:0] AGE_MAX = '1;

  logic [LAT_W-1:0] age [NUM_REGS];
  opClass_t         cls [NUM_REGS];
  logic [LAT_W-1:0] busyCnt [NUM_UNITS];

  // Per-register age since the latest accepted producer, saturating.
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        age[r] <= AGE_MAX;
        cls[r] <= CL_INT;
      end else if (strobe.regWr && dstTag == TAG_W'(r)) begin
        age[r] <= LAT_W'(1);
        cls[r] <= opClass;
      end else if (age[r] != AGE_MAX) begin
        age[r] <= age[r] + LAT_W'(1);
      end
    end
  end

  // Per-unit occupancy countdown.
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busyCnt[u] <= '0;
      end else if (strobe.unitLoad && strobe.unitSel == unit_t'(u + 1)) begin
        busyCnt[u] <= strobe.occLoad;
      end else if (busyCnt[u] != '0) begin
        busyCnt[u] <= busyCnt[u] - LAT_W'(1);
      end
    end
    assign unitBusy[u] = |busyCnt[u];
  end

  assign src0Age = age[src0Tag];
  assign src0Cls = cls[src0Tag];
  assign src1Age = age[src1Tag];
  assign src1Cls = cls[src1Tag];
endmodule

// File: rtl/lat_scoreboard_ctrl.sv
module lat_scoreboard_ctrl
  import lat_sb_pkg::*;
(
  input  logic                 issueValid,
  input  opClass_t             opClass,
  input  logic                 dstValid,
  input  logic                 src0Valid,
  input  logic                 src1Valid,
  input  logic [LAT_W-1:0]     src0Age,
  input  opClass_t             src0Cls,
  input  logic [LAT_W-1:0]     src1Age,
  input  opClass_t             src1Cls,
  input  logic [NUM_UNITS-1:0] unitBusy,
  output logic                 stall,
  output sbStrobe_t            strobe
);
  logic             src0Ok, src1Ok, busyHit, accept;
  unit_t            tgtUnit;
  logic [NUM_UNITS:0] busyExt;
  logic [LAT_W-1:0] occ;

  always_comb begin
    tgtUnit = unitOf(opClass);
    occ     = occOf(opClass);
    busyExt = {unitBusy, 1'b0};
    busyHit = busyExt[tgtUnit];
    src0Ok  = !src0Valid || (src0Age >= effLat(src0Cls, opClass));
    src1Ok  = !src1Valid || (src1Age >= effLat(src1Cls, opClass));
    stall   = issueValid && (!src0Ok || !src1Ok || busyHit);
    accept  = issueValid && !stall;

    strobe.regWr    = accept && dstValid;
    strobe.unitLoad = accept && (tgtUnit != UNIT_NONE) && (occ > LAT_W'(1));
    strobe.unitSel  = tgtUnit;
    strobe.occLoad  = occ - LAT_W'(1);
  end
endmodule

// File: rtl/lat_scoreboard.sv
module lat_scoreboard
  import lat_sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int TAG_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issueValid,
  input  logic [4:0]       opClass,
  input  logic             dstValid,
  input  logic [TAG_W-1:0] dstTag,
  input  logic             src0Valid,
  input  logic [TAG_W-1:0] src0Tag,
  input  logic             src1Valid,
  input  logic [TAG_W-1:0] src1Tag,
  output logic             stall
);
  sbStrobe_t            strobe;
  opClass_t             opCls;
  logic [LAT_W-1:0]     src0Age, src1Age;
  opClass_t             src0Cls, src1Cls;
  logic [NUM_UNITS-1:0] unitBusy;

  assign opCls = opClass_t'(opClass);

  lat_scoreboard_dp #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .dstTag(dstTag),
    .opClass(opCls), .src0Tag(src0Tag), .src1Tag(src1Tag),
    .src0Age(src0Age), .src0Cls(src0Cls), .src1Age(src1Age),
    .src1Cls(src1Cls), .unitBusy(unitBusy)
  );

  lat_scoreboard_ctrl u_ctrl (
    .issueValid(issueValid), .opClass(opCls), .dstValid(dstValid),
    .src0Valid(src0Valid), .src1Valid(src1Valid),
    .src0Age(src0Age), .src0Cls(src0Cls), .src1Age(src1Age),
    .src1Cls(src1Cls), .unitBusy(unitBusy), .stall(stall), .strobe(strobe)
  );
endmodule

// File: rtl/lat_scoreboard_chk.sv
module lat_scoreboard_chk #(
  parameter int TAG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issueValid,
  input logic [4:0]       opClass,
  input logic             dstValid,
  input logic [TAG_W-1:0] dstTag,
  input logic             src0Valid,
  input logic [TAG_W-1:0] src0Tag,
  input logic             stall
);
  AST_RESET_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_n) && issueValid) |-> !stall); // R1

  AST_INT_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && !stall && dstValid && opClass == 5'd0)
    |=> ((issueValid && src0Valid && src0Tag == $past(dstTag)) |-> stall)); // R2

  AST_RECCMP_BRANCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && !stall && dstValid && opClass == 5'd6)
    |=> ((issueValid && (opClass == 5'd18 || opClass == 5'd19) && src0Valid
          && src0Tag == $past(dstTag)) |-> stall)); // R4

  AST_DIV_UNIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && !stall && opClass == 5'd9)
    |=> !(issueValid && !stall && (opClass == 5'd9 || opClass == 5'd10))); // R8
endmodule

bind lat_scoreboard lat_scoreboard_chk #(.TAG_W(TAG_W)) u_chk (.*);

// File: tb/lat_scoreboard_tb.sv
module lat_scoreboard_tb;
  localparam int NREG = 32;
  localparam int TW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, issueValid, dstValid, src0Valid, src1Valid, stall;
  logic [4:0] opClass;
  logic [TW-1:0] dstTag, src0Tag, src1Tag;

  lat_scoreboard #(.NUM_REGS(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .opClass(opClass),
    .dstValid(dstValid), .dstTag(dstTag), .src0Valid(src0Valid),
    .src0Tag(src0Tag), .src1Valid(src1Valid), .src1Tag(src1Tag), .stall(stall)
  );

  int checks = 0, errors = 0, cyc = 0;
  int issueAt [NREG];
  int clsOf [NREG];
  int freeAt [4];
  bit done = 0;

  function automatic int latOf(int p, int c);
    int l;
    case (p)
      1: l = 4; 2: l = 6; 3: l = 6; 4: l = 5; 5: l = 3; 7: l = 5; 8: l = 7;
      9: l = 36; 10: l = 68; 11: l = 33; 12: l = 40; 14: l = 5; 15: l = 8;
      17: l = 6; default: l = 2;
    endcase
    if (p == 6 && (c == 18 || c == 19)) l = 4;
    if (c == 16) begin
      if (p == 13) l = 3;
      if (p == 14) l = 6;
      if (p == 15) l = 9;
      if (p == 17) l = 4;
    end
    if (c == 20) begin
      if (p == 13 || p == 16) l = 4;
      if (p == 14) l = 7;
      if (p == 15) l = 10;
    end
    return l;
  endfunction

  function automatic int unitFor(int c);
    if (c == 0 || c == 5 || c == 6 || c == 7 || c == 8) return 1;
    if (c == 9 || c == 10) return 2;
    if (c == 3 || c == 4 || c == 11 || c == 12) return 3;
    return 0;
  endfunction

  function automatic int occFor(int c);
    case (c)
      7: return 4; 8: return 6; 9: return 35; 10: return 67;
      11: return 28; 12: return 35; default: return 1;
    endcase
  endfunction

  function automatic bit modelStall();
    bit hold;
    int u;
    hold = 0;
    if (!issueValid) return 0;
    if (src0Valid && (cyc - issueAt[src0Tag]) < latOf(clsOf[src0Tag], int'(opClass))) hold = 1;
    if (src1Valid && (cyc - issueAt[src1Tag]) < latOf(clsOf[src1Tag], int'(opClass))) hold = 1;
    u = unitFor(int'(opClass));
    if (u != 0 && cyc < freeAt[u]) hold = 1;
    return hold;
  endfunction

  task automatic checkVal(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, int c, bit dv, int d, bit s0v, int s0, bit s1v, int s1,
                      string req, output bit st);
    bit exp;
    int u;
    @(negedge clk);
    issueValid = v; opClass = 5'(c); dstValid = dv; dstTag = TW'(d);
    src0Valid = s0v; src0Tag = TW'(s0); src1Valid = s1v; src1Tag = TW'(s1);
    #1;
    exp = modelStall();
    checkVal(req, int'(stall), int'(exp), "stall vs model");
    st = exp;
    @(posedge clk);
    if (v && !exp) begin
      if (dv) begin issueAt[d] = cyc; clsOf[d] = c; end
      u = unitFor(c);
      if (u != 0) freeAt[u] = cyc + occFor(c);
    end
    cyc++;
  endtask

  task automatic idle(int n);
    bit st;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R3", st);
  endtask

  task automatic waitIssue(int c, bit dv, int d, bit s0v, int s0, string req, output int n);
    bit st;
    n = 0;
    do begin
      step(1, c, dv, d, s0v, s0, 0, 0, req, st);
      if (st) n++;
    end while (st && n < 300);
  endtask

  // Producer into r1, then dependent consumer; count stall cycles.
  task automatic pairTest(int p, int c, int expStalls, string req);
    int n;
    idle(70);
    waitIssue(p, 1, 1, 0, 0, req, n);
    waitIssue(c, 1, 2, 1, 1, req, n);
    checkVal(req, n, expStalls, $sformatf("stalls class %0d -> %0d", p, c));
  endtask

  // Unit-occupying op, then an independent op aimed at the same unit.
  task automatic unitTest(int p, int c, int expStalls, string req);
    int n;
    idle(70);
    waitIssue(p, 1, 3, 0, 0, req, n);
    waitIssue(c, 1, 4, 0, 0, req, n);
    checkVal(req, n, expStalls, $sformatf("unit stalls class %0d then %0d", p, c));
  endtask

  initial begin
    #1600000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit st;
    int n;
    for (int i = 0; i < NREG; i++) begin issueAt[i] = -1000; clsOf[i] = 0; end
    for (int i = 0; i < 4; i++) freeAt[i] = 0;
    rst_n = 0; issueValid = 0; opClass = 0; dstValid = 0; dstTag = 0;
    src0Valid = 0; src0Tag = 0; src1Valid = 0; src1Tag = 0;
    repeat (3) @(posedge clk);
    #1 checkVal("R1", int'(stall), 0, "stall in reset");
    @(negedge clk) rst_n = 1;

    // R1: first operation after reset reads two registers and is accepted.
    step(1, 12, 1, 5, 1, 3, 1, 4, "R1", st);
    checkVal("R1", int'(st), 0, "first op after reset");
    step(1, 9, 1, 6, 1, 7, 1, 8, "R1", st);
    checkVal("R1", int'(stall), 0, "divide unit free after reset");

    // R2: default latencies, consumer is simple integer.
    pairTest(0, 0, 1, "R2");
    pairTest(1, 0, 3, "R2");
    pairTest(2, 0, 5, "R2");
    pairTest(3, 0, 5, "R2");
    pairTest(4, 0, 4, "R2");
    pairTest(5, 0, 2, "R2");
    pairTest(25, 0, 1, "R2");

    // R3: not-ready source with issueValid low never stalls.
    idle(70);
    waitIssue(2, 1, 1, 0, 0, "R3", n);
    step(0, 0, 1, 2, 1, 1, 0, 0, "R3", st);
    checkVal("R3", int'(stall), 0, "idle with hazard");

    // R4: record compare overrides.
    pairTest(6, 18, 3, "R4");
    pairTest(6, 19, 3, "R4");
    pairTest(6, 0, 1, "R4");

    // R5: vector to permute.
    pairTest(13, 16, 2, "R5");
    pairTest(14, 16, 5, "R5");
    pairTest(15, 16, 8, "R5");
    pairTest(17, 16, 3, "R5");
    pairTest(15, 13, 7, "R5");

    // R6: vector to store.
    pairTest(13, 20, 3, "R6");
    pairTest(16, 20, 3, "R6");
    pairTest(14, 20, 6, "R6");
    pairTest(15, 20, 9, "R6");

    // R7: multiply occupancy and latency.
    unitTest(7, 0, 3, "R7");
    unitTest(8, 5, 5, "R7");
    pairTest(7, 13, 4, "R7");
    pairTest(8, 13, 6, "R7");

    // R8: divide unit.
    unitTest(9, 10, 34, "R8");
    unitTest(10, 9, 66, "R8");
    unitTest(9, 0, 0, "R8");
    pairTest(9, 13, 35, "R8");

    // R9: FP long operations.
    unitTest(11, 3, 27, "R9");
    unitTest(12, 4, 34, "R9");
    pairTest(12, 13, 39, "R9");

    // R10: stalled op leaves its destination untouched.
    idle(70);
    waitIssue(12, 0, 0, 0, 0, "R10", n);
    step(1, 11, 1, 9, 0, 0, 0, 0, "R10", st);
    checkVal("R10", int'(stall), 1, "fdiv held by busy unit");
    step(1, 13, 1, 10, 1, 9, 0, 0, "R10", st);
    checkVal("R10", int'(stall), 0, "held op did not write r9");
    idle(40);
    waitIssue(11, 1, 11, 0, 0, "R10", n);
    checkVal("R10", n, 0, "unit not re-occupied by held op");

    // R11: no write without dstValid; invalid source ignored.
    idle(70);
    waitIssue(10, 0, 12, 0, 0, "R11", n);
    waitIssue(13, 1, 14, 1, 12, "R11", n);
    checkVal("R11", n, 0, "dstValid low writes nothing");
    waitIssue(17, 1, 15, 0, 0, "R11", n);
    step(1, 13, 1, 16, 0, 15, 0, 15, "R11", st);
    checkVal("R11", int'(st), 0, "invalid sources ignored");

    // R12: newer write replaces older.
    idle(70);
    waitIssue(2, 1, 17, 0, 0, "R12", n);
    waitIssue(13, 1, 17, 0, 0, "R12", n);
    waitIssue(0, 1, 18, 1, 17, "R12", n);
    checkVal("R12", n, 1, "latest producer governs");

    // Random mix checked against the model every cycle.
    idle(70);
    for (int i = 0; i < 1500; i++) begin
      step(($urandom % 4) != 0, $urandom % 21, $urandom % 2, $urandom % 8,
           $urandom % 2, $urandom % 8, $urandom % 2, $urandom % 8, "R3", st);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule